// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Status and Control Register

This block sends bytes on an asynchronous serial line. It has one holding buffer, an output shift register and one combined status and control register. A host writes bytes into the data port. It reads or writes the status register through a second strobe pair. Shifting is paced by an external bit-clock enable, and every state change on the line happens on a cycle where that enable is high.

The status register carries three kinds of flag:
- a buffer-empty flag;
- an underrun flag, cleared by reading the register, but only once the flag is at least one bit period old;
- an end-of-transmission flag, which is raised after the transmitter has been switched off and the frame in flight has been drained.

A break control holds the line low between frames. An auto-turnaround control raises a receiver-enable request once the drain completes. While the transmitter is off, a two-bit idle mode picks the line state:
- high impedance;
- driven low;
- driven high;
- internal loopback.

Top module: `serial_tx_stat`

## Requirements
- R1: After reset the status register reads 0x80. Buffer-empty is 1, and underrun, END, break, enable, auto-turnaround and idle mode are all 0. With idle mode 00 the line driver is off (`line_oe` = 0).
- R2: Status register layout: bit 0 is transmitter enable, bit 1 is break, bits 3:2 are the idle mode, bit 4 is auto-turnaround, bit 5 is END, bit 6 is underrun and bit 7 is buffer-empty. A status write updates bits 0 to 4 only.
- R3: A frame is sent as follows. On a bit tick where the transmitter is enabled, idle, not in break and the buffer is full, the line goes low (start bit). The 8 data bits follow, least significant first, one per tick. Then comes one high stop bit. The line changes only on ticks, and a buffered word starts on the tick after the stop bit.
- R4: Buffer-empty becomes 1 on the tick that moves the buffered word into the shift register. It becomes 0 in the cycle after a data write.
- R5: On the tick that ends a frame, underrun sets if the buffer is empty, break is off and the transmitter is enabled. A data write is accepted while underrun is set.
- R6: A status read clears underrun only if at least one bit tick has occurred since the flag set. An earlier read leaves it set. Disabling the transmitter clears underrun.
- R7: Underrun is raised at most once between two data writes, however many idle ticks pass.
- R8: A break bit written to 1 takes effect after the frame in flight has ended. From then the line is held low until the bit is written 0. The line then goes high for one tick before any buffered word is sent. While the break bit is 1, buffer-empty reads 0 and the buffered word is held.
- R9: If the buffer is empty when a break ends and a data write has occurred since the last underrun, underrun sets on the tick that ends the break.
- R10: A write of the break bit is ignored until the transmitter has been enabled for at least one bit tick. Disabling the transmitter also clears the break bit.
- R11: If the transmitter is disabled mid-frame, the frame completes and END sets on its final tick. If it is disabled while idle, END sets on the next tick. Writing enable = 1 clears END.
- R12: The receiver-enable request equals END AND auto-turnaround.
- R13: While the transmitter is disabled and no frame is in flight, the line follows the idle mode. 00 turns the driver off, 01 drives low, 10 drives high, and 11 drives high with `loop_sel` = 1. `loop_sel` is 1 exactly when the mode is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one tick per bit period |
| dat_wr | input | 1 | Data register write strobe |
| dat_in | input | DATA_W | Byte to transmit |
| st_wr | input | 1 | Status/control write strobe |
| st_wdata | input | 8 | Status/control write value |
| st_rd | input | 1 | Status read strobe (may clear underrun) |
| st_rdata | output | 8 | Status register contents |
| line_out | output | 1 | Serial line value |
| line_oe | output | 1 | Serial line driver enable |
| rx_en_req | output | 1 | Receiver-enable request after drain |
| loop_sel | output | 1 | Loopback routing select |

## Verification
The hardest state to reach from the ports is an underrun raised at the end of a break. It needs a data write since the last underrun, an empty buffer at the moment the break ends, and no underrun on the frame before the break.

The stimulus writes a word, sets the break bit while that word is shifting, and lets the frame drain into the break. It then clears a stale underrun with a read that is already old enough, and ends the break.

The read-before-one-tick case is reached by reading in the cycle right after the frame-end tick, before any further enable pulse. The frame checks use random bytes with random gaps between enable pulses.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [1:0] {
        IDLE_HIZ  = 2'b00,
        IDLE_LOW  = 2'b01,
        IDLE_HIGH = 2'b10,
        IDLE_LOOP = 2'b11
    } idle_mode_e;

    // packed so that it maps onto status bits 4..0
    typedef struct packed {
        logic       turn;
        idle_mode_e mode;
        logic       brk;
        logic       ena;
    } tx_ctrl_t;

    localparam int STAT_W = 8;

    function automatic tx_ctrl_t ctrl_from_word(input logic [STAT_W-1:0] w);
        tx_ctrl_t c;
        c.ena  = w[0];
        c.brk  = w[1];
        c.mode = idle_mode_e'(w[3:2]);
        c.turn = w[4];
        return c;
    endfunction

endpackage

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    output tx_ctrl_t          ctrl,
    output logic              ena_rise
);
    tx_ctrl_t ctrl_q;
    tx_ctrl_t wr_c;
    logic     settled_q;

    always_comb begin
        wr_c     = ctrl_from_word(st_wdata);
        ena_rise = st_wr && wr_c.ena && !ctrl_q.ena;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            settled_q <= 1'b0;
        end else begin
            if (st_wr) begin
                ctrl_q.ena  <= wr_c.ena;
                ctrl_q.mode <= wr_c.mode;
                ctrl_q.turn <= wr_c.turn;
                if (!wr_c.ena)
                    ctrl_q.brk <= 1'b0;
                else if (ctrl_q.ena && settled_q)
                    ctrl_q.brk <= wr_c.brk;
            end
            if (!ctrl_q.ena || (st_wr && !wr_c.ena))
                settled_q <= 1'b0;
            else if (bit_en)
                settled_q <= 1'b1;
        end
    end

    assign ctrl = ctrl_q;

    assert_brk_guard_R10: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_wdata[1] && !settled_q && !ctrl_q.brk) |=> !ctrl_q.brk);

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              ena,
    input  logic              brk,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_in,
    output logic              buf_full,
    output logic              line_q,
    output logic              busy,
    output logic              ur_event,
    output logic              stop_event
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W:0]   sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q, active_q, brk_on_q, armed_q, ln_q;
    logic              slot_tick, brk_start, brk_end, do_load;

    always_comb begin
        slot_tick  = bit_en && (cnt_q == '0);
        brk_start  = slot_tick && ena && brk && !brk_on_q;
        brk_end    = slot_tick && brk_on_q && !(ena && brk);
        do_load    = slot_tick && ena && !brk && !brk_on_q && full_q;
        ur_event   = slot_tick && armed_q && ena && !brk && !full_q
                     && (active_q || brk_on_q);
        stop_event = slot_tick && !ena;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            sh_q     <= '0;
            cnt_q    <= '0;
            full_q   <= 1'b0;
            active_q <= 1'b0;
            brk_on_q <= 1'b0;
            armed_q  <= 1'b0;
            ln_q     <= 1'b1;
        end else begin
            if (ur_event)
                armed_q <= 1'b0;
            if (dat_wr) begin
                hold_q  <= dat_in;
                full_q  <= 1'b1;
                armed_q <= 1'b1;
            end else if (do_load) begin
                full_q <= 1'b0;
            end
            if (bit_en) begin
                if (cnt_q != '0) begin
                    ln_q  <= sh_q[0];
                    sh_q  <= {1'b0, sh_q[DATA_W:1]};
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    active_q <= do_load;
                    if (brk_start) begin
                        brk_on_q <= 1'b1;
                        ln_q     <= 1'b0;
                    end else if (brk_end) begin
                        brk_on_q <= 1'b0;
                        ln_q     <= 1'b1;
                    end else if (do_load) begin
                        ln_q  <= 1'b0;
                        sh_q  <= {1'b1, hold_q};
                        cnt_q <= CNT_W'(DATA_W + 1);
                    end else if (!brk_on_q) begin
                        ln_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign buf_full = full_q;
    assign line_q   = ln_q;
    assign busy     = active_q || (cnt_q != '0);

    assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ln_q));

    assert_buf_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (brk_on_q && full_q) |=> full_q);

    assert_load_fill_R4: assert property (@(posedge clk) disable iff (rst)
        dat_wr |=> full_q);

endmodule

// File: rtl/serial_tx_flags.sv
module serial_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic ena,
    input  logic ena_rise,
    input  logic st_rd,
    input  logic ur_event,
    input  logic stop_event,
    output logic ur_flag,
    output logic end_flag
);
    logic ur_q, ripe_q, end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ur_q   <= 1'b0;
            ripe_q <= 1'b0;
            end_q  <= 1'b0;
        end else begin
            if (!ena) begin
                ur_q   <= 1'b0;
                ripe_q <= 1'b0;
            end else if (ur_event) begin
                ur_q   <= 1'b1;
                ripe_q <= 1'b0;
            end else if (st_rd && ripe_q) begin
                ur_q   <= 1'b0;
                ripe_q <= 1'b0;
            end else if (bit_en && ur_q) begin
                ripe_q <= 1'b1;
            end
            if (ena_rise)
                end_q <= 1'b0;
            else if (stop_event)
                end_q <= 1'b1;
        end
    end

    assign ur_flag  = ur_q;
    assign end_flag = end_q;

    assert_ur_early_R6: assert property (@(posedge clk) disable iff (rst)
        (ur_q && st_rd && !ripe_q && ena) |=> ur_q);

    assert_end_off_R11: assert property (@(posedge clk) disable iff (rst)
        end_q |-> !ena);

endmodule

// File: rtl/serial_tx_lineout.sv
module serial_tx_lineout
    import serial_tx_pkg::*;
(
    input  logic       ena,
    input  logic       busy,
    input  logic       line_q,
    input  idle_mode_e mode,
    output logic       line_out,
    output logic       line_oe,
    output logic       loop_sel
);
    always_comb begin
        loop_sel = (mode == IDLE_LOOP);
        if (ena || busy) begin
            line_out = line_q;
            line_oe  = 1'b1;
        end else begin
            unique case (mode)
                IDLE_HIZ:  begin line_out = 1'b1; line_oe = 1'b0; end
                IDLE_LOW:  begin line_out = 1'b0; line_oe = 1'b1; end
                IDLE_HIGH: begin line_out = 1'b1; line_oe = 1'b1; end
                default:   begin line_out = 1'b1; line_oe = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/serial_tx_stat.sv
module serial_tx_stat
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_in,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    input  logic              st_rd,
    output logic [STAT_W-1:0] st_rdata,
    output logic              line_out,
    output logic              line_oe,
    output logic              rx_en_req,
    output logic              loop_sel
);
    tx_ctrl_t ctrl;
    logic     ena_rise, buf_full, line_q, busy, ur_event, stop_event;
    logic     ur_flag, end_flag, be_flag;

    serial_tx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .st_wr(st_wr), .st_wdata(st_wdata),
        .ctrl(ctrl), .ena_rise(ena_rise)
    );

    serial_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .ena(ctrl.ena), .brk(ctrl.brk),
        .dat_wr(dat_wr), .dat_in(dat_in),
        .buf_full(buf_full), .line_q(line_q), .busy(busy),
        .ur_event(ur_event), .stop_event(stop_event)
    );

    serial_tx_flags u_flags (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .ena(ctrl.ena), .ena_rise(ena_rise), .st_rd(st_rd),
        .ur_event(ur_event), .stop_event(stop_event),
        .ur_flag(ur_flag), .end_flag(end_flag)
    );

    serial_tx_lineout u_line (
        .ena(ctrl.ena), .busy(busy), .line_q(line_q), .mode(ctrl.mode),
        .line_out(line_out), .line_oe(line_oe), .loop_sel(loop_sel)
    );

    assign be_flag   = !buf_full && !ctrl.brk;
    assign st_rdata  = {be_flag, ur_flag, end_flag, ctrl};
    assign rx_en_req = end_flag && ctrl.turn;

endmodule

// File: tb/test_serial_tx_stat.sv
`timescale 1ns/1ps
module test_serial_tx_stat;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0, dat_wr = 1'b0, st_wr = 1'b0, st_rd = 1'b0;
    logic [7:0] dat_in = '0, st_wdata = '0;
    logic [7:0] st_rdata;
    logic       line_out, line_oe, rx_en_req, loop_sel;
    int         total = 0, bad = 0;
    logic [7:0] bytes [6];

    always #5 clk = ~clk;

    serial_tx_stat i_serial_tx_stat (
        .clk(clk), .rst(rst), .bit_en(bit_en), .dat_wr(dat_wr), .dat_in(dat_in),
        .st_wr(st_wr), .st_wdata(st_wdata), .st_rd(st_rd), .st_rdata(st_rdata),
        .line_out(line_out), .line_oe(line_oe), .rx_en_req(rx_en_req),
        .loop_sel(loop_sel)
    );

    function automatic logic [7:0] stat(input logic be, ur, fin, turn,
                                        input logic [1:0] mode,
                                        input logic brk, ena);
        return {be, ur, fin, turn, mode, brk, ena};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic tick();
        bit_en = 1'b1; @(negedge clk); bit_en = 1'b0;
    endtask
    task automatic ticks(input int n);
        repeat (n) tick();
    endtask
    task automatic wr_dat(input logic [7:0] b);
        dat_wr = 1'b1; dat_in = b; @(negedge clk); dat_wr = 1'b0;
    endtask
    task automatic wr_st(input logic [7:0] v);
        st_wr = 1'b1; st_wdata = v; @(negedge clk); st_wr = 1'b0;
    endtask
    task automatic rd_st();
        st_rd = 1'b1; @(negedge clk); st_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        foreach (bytes[i]) bytes[i] = 8'($urandom);
        cyc(3); rst = 1'b0; cyc(1);

        // R1 reset state
        chk("R1 status", st_rdata, 32'h80);
        chk("R1 oe", line_oe, 0);
        chk("R12 rx_en_req", rx_en_req, 0);

        // R13 idle modes while disabled
        wr_st(8'h04); chk("R13 low out", {line_oe, line_out}, 2'b10);
        wr_st(8'h08); chk("R13 high out", {line_oe, line_out}, 2'b11);
        chk("R13 no loop", loop_sel, 0);
        wr_st(8'h0C); chk("R13 loop", {loop_sel, line_oe, line_out}, 3'b111);
        chk("R2 mode field", st_rdata, stat(1,0,0,0,2'b11,0,0));

        // enable, mode 00
        wr_st(8'h01);
        chk("R2 enabled", st_rdata, 32'h81);
        chk("R13 enabled drives mark", {line_oe, line_out}, 2'b11);
        tick();
        chk("R7 no underrun before any write", st_rdata[6], 0);

        // R3/R4 random back-to-back frames with random tick gaps
        wr_dat(bytes[0]);
        chk("R4 be clears on write", st_rdata[7], 0);
        for (int i = 0; i < 6; i++) begin
            cyc($urandom_range(0, 2)); tick();
            chk("R3 start bit", line_out, 0);
            chk("R4 be sets on load", st_rdata[7], 1);
            if (i < 5) wr_dat(bytes[i+1]);
            for (int k = 0; k < 8; k++) begin
                cyc($urandom_range(0, 2)); tick();
                chk("R3 data bit", line_out, bytes[i][k]);
            end
            tick();
            chk("R3 stop bit", line_out, 1);
            chk("R5 no underrun mid stream", st_rdata[6], 0);
        end
        tick();
        chk("R5 underrun at frame end", st_rdata, stat(1,1,0,0,2'b00,0,1));

        // R6 early read does not clear
        rd_st();
        chk("R6 early read keeps flag", st_rdata[6], 1);
        tick();
        chk("R6 flag still set", st_rdata[6], 1);
        rd_st();
        chk("R6 ripe read clears", st_rdata[6], 0);

        // R7 single underrun per write
        ticks(5);
        chk("R7 no second underrun", st_rdata[6], 0);

        // R8 break: word waits, line low
        wr_dat(8'h5A); tick();
        wr_st(8'h03);
        chk("R8 be held low in break", st_rdata, stat(0,0,0,0,2'b00,1,1));
        ticks(9); tick();
        chk("R8 break line low", line_out, 0);
        chk("R8 no underrun into break", st_rdata[6], 0);
        wr_dat(8'hC3);
        ticks(3);
        chk("R8 break persists", line_out, 0);
        chk("R8 be reads 0 while held", st_rdata[7], 0);
        wr_st(8'h01);
        tick();
        chk("R8 break end mark", line_out, 1);
        chk("R9 full buffer no underrun", st_rdata[6], 0);
        tick();
        chk("R8 held word starts", {line_out, st_rdata[7]}, 2'b01);
        for (int k = 0; k < 8; k++) begin
            tick(); chk("R8 held word bit", line_out, 1'((8'hC3 >> k) & 1));
        end
        tick(); tick();
        chk("R5 underrun after held word", st_rdata[6], 1);

        // R5 write with underrun pending
        wr_dat(8'h96); tick();
        chk("R5 write accepted with flag set", {line_out, st_rdata[7]}, 2'b01);

        // R9 break end with empty buffer
        wr_st(8'h03);
        ticks(10);
        chk("R9 break entered", line_out, 0);
        rd_st();
        chk("R6 clear before break end", st_rdata[6], 0);
        wr_st(8'h01);
        tick();
        chk("R9 underrun at break end", st_rdata[6], 1);

        // R11 disable mid frame, R6 disable clears, R12 turnaround
        wr_dat(8'h3C); tick();
        wr_st(8'h18);
        cyc(1);
        chk("R6 disable clears underrun", st_rdata[6], 0);
        for (int k = 0; k < 8; k++) begin
            tick(); chk("R11 drain bit", {line_oe, line_out}, {1'b1, 1'((8'h3C >> k) & 1)});
        end
        tick();
        chk("R11 no END before frame end", st_rdata[5], 0);
        chk("R12 no request yet", rx_en_req, 0);
        tick();
        chk("R11 END after drain", st_rdata, 32'hB8);
        chk("R12 request", rx_en_req, 1);
        chk("R13 high after drain", {line_oe, line_out}, 2'b11);
        wr_st(8'h01);
        chk("R11 re-enable clears END", st_rdata, 32'h81);

        // R11 idle disable
        wr_st(8'h00);
        chk("R11 END waits for tick", st_rdata[5], 0);
        chk("R13 hiz", line_oe, 0);
        tick();
        chk("R11 END on idle disable", st_rdata[5], 1);

        // R10 break guard
        wr_st(8'h01);
        wr_st(8'h03);
        chk("R10 break ignored before tick", st_rdata[1], 0);
        tick();
        chk("R10 line mark without break", line_out, 1);
        wr_st(8'h03);
        chk("R10 break accepted", st_rdata[1], 1);
        tick();
        chk("R10 break drives low", line_out, 0);
        wr_st(8'h00);
        chk("R10 disable clears break", st_rdata[1], 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule